// File: doc/BRIEF.md
# Capture-Compare Timer with Compare Shortcuts

This block is an up-counter for time measurement and periodic event generation. A base clock is divided by a power of two, chosen by a prescale code, and each divided tick advances the counter by one. The counter wraps from all ones back to zero. A parameterised number of channels each hold one value register. That register can be loaded by software as a compare value, or it can be filled by a capture pulse with a snapshot of the counter.

When the counter takes a channel's value on a tick, that channel's event flag latches and stays set until software clears it. Two shortcut bit sets can turn such a match into a hardware action with no software latency. One set makes the counter fall back to zero, which gives a programmable period. The other set halts counting, which gives a one-shot. Start, stop, clear and capture act on a write of one over a small register bus, or on single-cycle pulses at dedicated pins that other logic can drive. An interrupt line combines the event flags that software has enabled. The enables are updated through separate set and clear addresses, so no read-modify-write is needed.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter is stopped and at zero, and it stays at zero while stopped. Every channel value is zero. Every event flag, shortcut bit and interrupt enable is clear. `irq` is low, and the prescale code reads 4.
- R2: While running, with prescale code p (0..9), the counter gains one every 2^p clock cycles. The first increment lands 2^p cycles after the edge that starts it, so a capture issued M cycles after the start returns M>>p. The prescale code sits in bits [3:0] at address 0x23.
- R3: A prescale write is ignored while the counter runs, and it is also ignored when the written value exceeds 9.
- R4: The counter wraps from all ones (2^CNT_W - 1) to zero and keeps counting. A channel holding zero matches on that wrap.
- R5: A capture, either a write of bit0=1 to address 0x08+n or a pulse on `trig_capture[n]`, loads channel n with the count held before that clock edge.
- R6: Event flag n (bit0 of address 0x10+n, also `cmp_evt[n]`) sets on the edge where a tick brings the counter to channel n's value. It stays set until bit0=0 is written there. Writing bit0=1 has no effect.
- R7: When shortcut bit n (address 0x20) is set, a tick that would bring the counter to channel n's value loads zero instead and still sets event n. With value V the counter therefore runs 0..V-1.
- R8: When shortcut bit 8+n is set, a match on channel n stops the counter, which holds the matched value.
- R9: Writing ones at bits 16+n of address 0x21 sets interrupt enable n, and writing ones at the same bits of address 0x22 clears it. Zero bits leave enables unchanged. Both addresses read back the enables at bits 16+n.
- R10: `irq` is a register that goes high one cycle after any event flag whose enable is set, and it stays low for flags that are not enabled.
- R11: A clear (bit0=1 at address 0x02, or `trig_clear`) zeroes the counter and the prescale phase whether the counter is running or stopped. A tick in the same cycle is dropped, so the clear wins over a compare.
- R12: A start (0x00 or `trig_start`) runs the counter, and a stop (0x01 or `trig_stop`) halts it. A stop beats a start in the same cycle and suppresses that cycle's tick.
- R13: Channel n's value is at address 0x40+n. Writes keep the low CNT_W bits, and reads return the value zero-extended to 32 bits. A read strobe returns data in `bus_rdata` one cycle later, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (undivided tick source) |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |
| trig_start | input | 1 | Start pulse |
| trig_stop | input | 1 | Stop pulse |
| trig_clear | input | 1 | Clear pulse |
| trig_capture | input | NUM_CH | Per-channel capture pulses |
| cmp_evt | output | NUM_CH | Latched compare event flags |
| irq | output | 1 | Registered combined interrupt |

## Verification
Every trigger acts on the clock edge that ends its request cycle. The counter therefore first moves 2^p cycles after the start edge, and a capture holds the count from before its own edge. An event flag appears on the edge of the matching tick, and `irq` follows one edge later. The bench drives and samples on falling edges and counts the rising edges between stimulus and observation, so each expected count is a closed formula such as M>>p or M mod V. Flags and `irq` are checked on the exact falling edge before and after they are due.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int BUS_DW = 32;
  localparam int BUS_AW = 8;

  // register word addresses
  localparam logic [BUS_AW-1:0] A_START    = 8'h00;
  localparam logic [BUS_AW-1:0] A_STOP     = 8'h01;
  localparam logic [BUS_AW-1:0] A_CLEAR    = 8'h02;
  localparam logic [BUS_AW-1:0] A_CAP_BASE = 8'h08;
  localparam logic [BUS_AW-1:0] A_EVT_BASE = 8'h10;
  localparam logic [BUS_AW-1:0] A_SHORT    = 8'h20;
  localparam logic [BUS_AW-1:0] A_INTSET   = 8'h21;
  localparam logic [BUS_AW-1:0] A_INTCLR   = 8'h22;
  localparam logic [BUS_AW-1:0] A_PSC      = 8'h23;
  localparam logic [BUS_AW-1:0] A_CC_BASE  = 8'h40;

  // field positions decoded by neighbours
  localparam int SH_STOP_OFS = 8;
  localparam int INT_OFS     = 16;

  typedef struct packed {
    logic start;
    logic stop;
    logic clear;
  } ctl_req_t;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int PSC_MAX = 9,
  parameter int PSC_W   = 4,
  parameter int DIV_W   = PSC_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             phase_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low p bits of the mask set: a tick every 2^p running cycles
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(psc));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign phase_tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_tick,
  input  ctl_req_t          req,
  input  logic [NUM_CH-1:0] match,
  input  logic [NUM_CH-1:0] sh_clr,
  input  logic [NUM_CH-1:0] sh_stop,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cnt_next,
  output logic              running,
  output logic [NUM_CH-1:0] hit
);
  logic adv;
  logic wrap_zero;
  logic halt;

  // a stop or clear in the same cycle swallows the tick
  assign adv       = phase_tick && !req.stop && !req.clear;
  assign cnt_next  = count + 1'b1;
  assign hit       = match & {NUM_CH{adv}};
  assign wrap_zero = |(hit & sh_clr);
  assign halt      = |(hit & sh_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (req.clear) begin
      count <= '0;
    end else if (adv) begin
      count <= wrap_zero ? '0 : cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (req.stop || halt) begin
      running <= 1'b0;
    end else if (req.start) begin
      running <= 1'b1;
    end
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_now,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             cap_req,
  input  logic             val_we,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             evt_clr_we,
  input  logic             hit,
  output logic             match,
  output logic [CNT_W-1:0] val_q,
  output logic             evt_q
);
  assign match = (cnt_next == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (cap_req) begin
      val_q <= cnt_now;
    end else if (val_we) begin
      val_q <= val_wdata;
    end
  end

  // hardware set beats a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
    end else if (hit) begin
      evt_q <= 1'b1;
    end else if (evt_clr_we) begin
      evt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 32,
  parameter int PSC_MAX = 9,
  parameter int PSC_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              trig_start,
  input  logic              trig_stop,
  input  logic              trig_clear,
  input  logic [NUM_CH-1:0] trig_capture,
  output logic [NUM_CH-1:0] cmp_evt,
  output logic              irq
);
  localparam int PSC_W = $clog2(PSC_MAX + 1);

  ctl_req_t          req;
  logic              start_req, stop_req, clear_req;
  logic              running;
  logic              phase_tick;
  logic [CNT_W-1:0]  count, cnt_next;
  logic [NUM_CH-1:0] match, hit, cap_req, val_we, evt_clr_we, evt_q;
  logic [CNT_W-1:0]  cc_val [NUM_CH];
  logic [NUM_CH-1:0] sh_clr, sh_stop, int_en;
  logic [PSC_W-1:0]  psc_q;
  logic [BUS_DW-1:0] rd_val;
  logic              go;

  assign go        = bus_wr && bus_wdata[0];
  assign start_req = trig_start || (go && bus_addr == A_START);
  assign stop_req  = trig_stop  || (go && bus_addr == A_STOP);
  assign clear_req = trig_clear || (go && bus_addr == A_CLEAR);
  assign req       = '{start: start_req, stop: stop_req, clear: clear_req};

  cct_prescaler #(.PSC_MAX(PSC_MAX), .PSC_W(PSC_W), .DIV_W(PSC_MAX)) u_psc (
    .clk(clk), .rst(rst), .run(running), .restart(clear_req),
    .psc(psc_q), .phase_tick(phase_tick)
  );

  cct_counter #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cnt (
    .clk(clk), .rst(rst), .phase_tick(phase_tick), .req(req),
    .match(match), .sh_clr(sh_clr), .sh_stop(sh_stop),
    .count(count), .cnt_next(cnt_next), .running(running), .hit(hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign cap_req[n]    = trig_capture[n] || (go && bus_addr == A_CAP_BASE + BUS_AW'(n));
    assign val_we[n]     = bus_wr && bus_addr == A_CC_BASE + BUS_AW'(n);
    assign evt_clr_we[n] = bus_wr && !bus_wdata[0] && bus_addr == A_EVT_BASE + BUS_AW'(n);

    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt_now(count), .cnt_next(cnt_next),
      .cap_req(cap_req[n]), .val_we(val_we[n]), .val_wdata(bus_wdata[CNT_W-1:0]),
      .evt_clr_we(evt_clr_we[n]), .hit(hit[n]),
      .match(match[n]), .val_q(cc_val[n]), .evt_q(evt_q[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_clr  <= '0;
      sh_stop <= '0;
    end else if (bus_wr && bus_addr == A_SHORT) begin
      sh_clr  <= bus_wdata[NUM_CH-1:0];
      sh_stop <= bus_wdata[SH_STOP_OFS +: NUM_CH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en <= '0;
    end else if (bus_wr && bus_addr == A_INTSET) begin
      int_en <= int_en | bus_wdata[INT_OFS +: NUM_CH];
    end else if (bus_wr && bus_addr == A_INTCLR) begin
      int_en <= int_en & ~bus_wdata[INT_OFS +: NUM_CH];
    end
  end

  // rate changes only while halted and only for legal codes
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= PSC_W'(PSC_RST);
    end else if (bus_wr && bus_addr == A_PSC && !running &&
                 bus_wdata <= BUS_DW'(PSC_MAX)) begin
      psc_q <= bus_wdata[PSC_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_SHORT) begin
      rd_val[NUM_CH-1:0]              = sh_clr;
      rd_val[SH_STOP_OFS +: NUM_CH]   = sh_stop;
    end else if (bus_addr == A_INTSET || bus_addr == A_INTCLR) begin
      rd_val[INT_OFS +: NUM_CH]       = int_en;
    end else if (bus_addr == A_PSC) begin
      rd_val[PSC_W-1:0]               = psc_q;
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == A_EVT_BASE + BUS_AW'(n)) rd_val[0] = evt_q[n];
      if (bus_addr == A_CC_BASE + BUS_AW'(n))  rd_val = BUS_DW'(cc_val[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      irq <= |(evt_q & int_en);
    end
  end

  assign cmp_evt = evt_q;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              stop_req,
  input logic              clear_req,
  input logic              running,
  input logic [CNT_W-1:0]  count,
  input logic [NUM_CH-1:0] cmp_evt,
  input logic [NUM_CH-1:0] int_en,
  input logic              irq
);
  assert_stop_halts_R12: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !running);

  assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (count == '0));

  assert_irq_lags_flags_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(cmp_evt & int_en))));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (rst)
    !clear_req |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (!running && !clear_req) |=> $stable(count));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_evt
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (cmp_evt[n] && !(bus_wr && !bus_wdata[0] && bus_addr == A_EVT_BASE + BUS_AW'(n)))
      |=> cmp_evt[n]);
  end
endmodule

bind cct_timer cct_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .stop_req(stop_req), .clear_req(clear_req), .running(running), .count(count),
  .cmp_evt(cmp_evt), .int_en(int_en), .irq(irq)
);

// File: tb/tb_cct_timer.sv
module tb_cct_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  localparam logic [7:0] A_START = 8'h00, A_STOP = 8'h01, A_CLEAR = 8'h02,
                         A_CAP = 8'h08, A_EVT = 8'h10, A_SHORT = 8'h20,
                         A_INTSET = 8'h21, A_INTCLR = 8'h22, A_PSC = 8'h23,
                         A_CC = 8'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic trig_start = 1'b0, trig_stop = 1'b0, trig_clear = 1'b0;
  logic [NCH-1:0] trig_capture = '0;
  logic [NCH-1:0] cmp_evt;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cct_timer #(.NUM_CH(NCH), .CNT_W(8)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_start(trig_start),
    .trig_stop(trig_stop), .trig_clear(trig_clear), .trig_capture(trig_capture),
    .cmp_evt(cmp_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic cap(input int n, output logic [31:0] v);
    wr(A_CAP + 8'(n), 32'd1);
    rd(A_CC + 8'(n), v);
  endtask

  task automatic clr_events();
    for (int n = 0; n < NCH; n++) wr(A_EVT + 8'(n), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 events", 32'(cmp_evt), 0);
    rd(A_PSC, v);    chk("R1 prescale", v, 4);
    rd(A_SHORT, v);  chk("R1 shortcuts", v, 0);
    rd(A_INTSET, v); chk("R1 enables", v, 0);
    for (int n = 0; n < NCH; n++) begin
      rd(A_CC + 8'(n), v); chk("R1 channel value", v, 0);
    end
    repeat (20) @(negedge clk);
    cap(0, v); chk("R1 idle count", v, 0);

    // R2 / R3 prescale sweep
    for (int p = 0; p <= 9; p++) begin
      wr(A_STOP, 1);
      wr(A_PSC, 32'(p));
      rd(A_PSC, v); chk("R2 prescale readback", v, 32'(p));
      wr(A_CLEAR, 1);
      wr(A_START, 1);
      repeat ((6 << p) - 1) @(negedge clk);
      wr(A_CAP + 8'd1, 1);
      wr(A_PSC, 32'((p + 3) % 10));
      rd(A_PSC, v); chk("R3 running write ignored", v, 32'(p));
      wr(A_STOP, 1);
      rd(A_CC + 8'd1, v); chk("R2 ticks = M>>p", v, 5);
    end
    wr(A_PSC, 12);
    rd(A_PSC, v); chk("R3 out-of-range ignored", v, 9);

    // R4 wrap, R10 irq latency, R6 flag behaviour
    wr(A_PSC, 0);
    for (int n = 0; n < NCH; n++) wr(A_CC + 8'(n), 0);
    clr_events();
    wr(A_INTSET, 32'h0001_0000);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    repeat (255) @(negedge clk);
    chk("R6 no flag before match", 32'(cmp_evt[0]), 0);
    @(negedge clk);
    chk("R4 match on wrap to zero", 32'(cmp_evt[0]), 1);
    chk("R10 irq one cycle late", 32'(irq), 0);
    @(negedge clk);
    chk("R10 irq raised", 32'(irq), 1);
    cap(0, v); chk("R4 count after wrap", v, 1);
    wr(A_STOP, 1);
    rd(A_EVT, v); chk("R6 flag persists", v, 1);
    wr(A_EVT, 1);
    rd(A_EVT, v); chk("R6 write one no effect", v, 1);
    wr(A_EVT, 0);
    rd(A_EVT, v); chk("R6 write zero clears", v, 0);
    chk("R10 irq drops", 32'(irq), 0);

    // R9 enable set/clear
    wr(A_INTCLR, 32'h000F_0000);
    wr(A_INTSET, 32'h000F_0000);
    rd(A_INTSET, v); chk("R9 set", v, 32'h000F_0000);
    wr(A_INTSET, 0);
    rd(A_INTCLR, v); chk("R9 zeros ignored on set", v, 32'h000F_0000);
    wr(A_INTCLR, 32'h0005_0000);
    rd(A_INTSET, v); chk("R9 clear", v, 32'h000A_0000);
    wr(A_INTCLR, 0);
    rd(A_INTSET, v); chk("R9 zeros ignored on clear", v, 32'h000A_0000);

    // R6 exact timing, R10 disabled flag
    wr(A_INTCLR, 32'h000F_0000);
    clr_events();
    wr(A_CC + 8'd0, 200); wr(A_CC + 8'd1, 200); wr(A_CC + 8'd3, 200);
    wr(A_CC + 8'd2, 5);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    repeat (4) @(negedge clk);
    chk("R6 flag not yet", 32'(cmp_evt[2]), 0);
    @(negedge clk);
    chk("R6 flag on match edge", 32'(cmp_evt[2]), 1);
    @(negedge clk);
    chk("R10 disabled flag keeps irq low", 32'(irq), 0);
    wr(A_STOP, 1);

    // R7 clear shortcut
    clr_events();
    wr(A_CC + 8'd1, 3);
    wr(A_SHORT, 32'h2);
    rd(A_SHORT, v); chk("R7 shortcut readback", v, 2);
    for (int m = 0; m <= 8; m++) begin
      wr(A_STOP, 1);
      wr(A_CLEAR, 1);
      wr(A_START, 1);
      repeat (m) @(negedge clk);
      cap(3, v); chk("R7 period M mod 3", v, 32'(m % 3));
    end
    wr(A_STOP, 1);
    chk("R7 event still set", 32'(cmp_evt[1]), 1);

    // R8 stop shortcut
    wr(A_SHORT, 32'h400);
    rd(A_SHORT, v); chk("R8 shortcut readback", v, 32'h400);
    wr(A_CC + 8'd2, 7);
    wr(A_PSC, 1);
    clr_events();
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    repeat (40) @(negedge clk);
    cap(3, v); chk("R8 halted at match", v, 7);
    chk("R8 event set", 32'(cmp_evt[2]), 1);
    repeat (20) @(negedge clk);
    cap(3, v); chk("R8 stays halted", v, 7);

    // R11 clear when stopped and running
    wr(A_CLEAR, 1);
    cap(3, v); chk("R11 clear while stopped", v, 0);
    wr(A_SHORT, 0);
    wr(A_PSC, 0);
    wr(A_CC + 8'd3, 200);
    wr(A_START, 1);
    repeat (20) @(negedge clk);
    trig_clear = 1'b1;
    @(negedge clk);
    trig_clear = 1'b0;
    cap(3, v); chk("R11 clear while running", v, 0);
    wr(A_STOP, 1);

    // R11 clear beats compare
    wr(A_CC + 8'd0, 1);
    wr(A_CC + 8'd3, 200);
    clr_events();
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    trig_clear = 1'b1;
    @(negedge clk);
    trig_clear = 1'b0;
    trig_stop = 1'b1;
    @(negedge clk);
    trig_stop = 1'b0;
    chk("R11 no event when clear wins", 32'(cmp_evt[0]), 0);
    cap(3, v); chk("R11 count zero", v, 0);

    // R12 start/stop priority
    trig_start = 1'b1; trig_stop = 1'b1;
    @(negedge clk);
    trig_start = 1'b0; trig_stop = 1'b0;
    repeat (10) @(negedge clk);
    cap(3, v); chk("R12 stop wins from idle", v, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    repeat (10) @(negedge clk);
    trig_start = 1'b1; trig_stop = 1'b1;
    @(negedge clk);
    trig_start = 1'b0; trig_stop = 1'b0;
    cap(3, v1); chk("R12 stop suppresses tick", v1, 10);
    repeat (10) @(negedge clk);
    cap(3, v2); chk("R12 remains stopped", v2, v1);

    // R5 pin capture
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    repeat (17) @(negedge clk);
    trig_capture = 4'b0100;
    @(negedge clk);
    trig_capture = '0;
    rd(A_CC + 8'd2, v); chk("R5 pin capture", v, 17);
    wr(A_STOP, 1);

    // R13 value access and decode
    wr(A_CC + 8'd0, 32'hA5);
    rd(A_CC + 8'd0, v); chk("R13 value readback", v, 32'hA5);
    wr(A_CC + 8'd0, 32'h1234);
    rd(A_CC + 8'd0, v); chk("R13 truncated to CNT_W", v, 32'h34);
    rd(8'h30, v); chk("R13 unmapped reads zero", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule